// File: doc/BRIEF.md
# Pipelined Read Return Tracker

This block follows the read requests that a graphics bus master has put into the arbiter's pipeline and that are still waiting for data. Each accepted request gets a sequence tag and joins one of two in-order queues, one for low priority and one for high priority. The 3-bit arbiter status bus has meaning only while grant is asserted. The block decodes it to learn which class the present data belongs to, counts the 8-byte data beats against the request at the head of that class, and reports the request's tag when its last beat arrives.

The block also models occupancy of the receive buffer that takes low-priority data. From that occupancy it drives a buffer-full output, with hysteresis, which tells the arbiter to stop returning low-priority data. High-priority returns do not use that buffer and are never held back by it. A tracker-full flag stops the enqueue side once four requests are outstanding across both classes. A sticky error flag records a return code that names a class with nothing outstanding.

Top module: `rd_return_tracker`

## Requirements
- R1: While `arb_gnt` is low, the value on `arb_status` has no effect. No beat is counted, no completion is reported and the error flag does not change.
- R2: With `arb_gnt` high, status code 3'b000 together with `rd_beat` counts one beat against the oldest low-priority request. Status code 3'b001 together with `rd_beat` counts one beat against the oldest high-priority request.
- R3: With `arb_gnt` high, status codes 3'b010, 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 cause no beat, no completion and no error.
- R4: Tags are handed out in acceptance order, starting at 0 after reset, incrementing by one for each accepted request and wrapping modulo 2^TAG_W across both classes. Within each class, completions occur in request order.
- R5: A length field of n means n+1 beats. On the clock edge that samples the final beat, `done_valid` is set for one cycle, with `done_tag` set to the request's tag and `done_hi` set to 1 for high priority.
- R6: `tracker_full` is high exactly when 4 requests (DEPTH) are outstanding in total. A request offered while it is high is dropped and does not consume a tag.
- R7: Receive-buffer occupancy rises by one for each counted low-priority beat and falls by one for each `rxbuf_take` pulse, and it saturates at 0 and at BUF_BEATS. `rd_buf_full` is set when occupancy exceeds BUF_BEATS-MAX_BEATS (4 by default), cleared when occupancy falls below it, and held when occupancy equals it.
- R8: High-priority beats do not change the receive-buffer occupancy, and `rd_buf_full` does not block them.
- R9: `proto_err` becomes 1 when, with grant high, status 3'b000 arrives while the low queue is empty or status 3'b001 arrives while the high queue is empty. It stays 1 until reset.
- R10: After reset, `tracker_full`, `rd_buf_full`, `done_valid` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A read request is put into the pipeline this cycle |
| req_hi | input | 1 | Priority of the request: 1 for high |
| req_len | input | LEN_W | Request length in beats, minus one |
| arb_gnt | input | 1 | Grant from the arbiter; qualifies arb_status |
| arb_status | input | 3 | Arbiter status code |
| rd_beat | input | 1 | One 8-byte read data beat is present |
| rxbuf_take | input | 1 | One beat leaves the low-priority receive buffer |
| tracker_full | output | 1 | DEPTH requests are outstanding; stop enqueueing |
| rd_buf_full | output | 1 | Low-priority returns must be held off |
| done_valid | output | 1 | A request finished on the previous edge |
| done_hi | output | 1 | Priority of the finished request |
| done_tag | output | TAG_W | Tag of the finished request |
| proto_err | output | 1 | Sticky: a return named a class with nothing outstanding |

## Verification
On every cycle the assertions check three things. Grant low or a non-read status code is never followed by a completion. The total outstanding count never exceeds four. The buffer-full output only rises above the threshold and only falls below it, and the error flag never clears. Only the bench scenarios can show that beats land on the right queue, that completion tags come out in the correct order with a blocked enqueue consuming no tag, and that a high-priority return leaves the buffer occupancy untouched. Those scenarios reveal the occupancy through the exact number of take pulses needed to release buffer-full.

// File: rtl/rdt_pkg.sv
// Shared types for the read return tracker.
// Assumes the arbiter status bus is 3 bits wide.
package rdt_pkg;

    typedef enum logic [2:0] {
        ST_LO_RD = 3'b000,
        ST_HI_RD = 3'b001,
        ST_LO_WR = 3'b010,
        ST_HI_WR = 3'b011,
        ST_RSV4  = 3'b100,
        ST_RSV5  = 3'b101,
        ST_RSV6  = 3'b110,
        ST_START = 3'b111
    } arb_status_e;

endpackage

// File: rtl/rdt_status_decode.sv
// Decodes the arbiter status bus into low and high read-return strobes.
// Assumes: status carries meaning only while grant is high; write and
// start codes, and reserved codes, produce neither strobe.
module rdt_status_decode
    import rdt_pkg::*;
(
    input  logic       gnt,
    input  logic [2:0] status,
    output logic       lo_ret,
    output logic       hi_ret
);

    arb_status_e code;

    // Qualify the status code with grant and pick out the two read-return codes
    always_comb begin
        code   = arb_status_e'(status);
        lo_ret = gnt && (code == ST_LO_RD);
        hi_ret = gnt && (code == ST_HI_RD);
    end

endmodule

// File: rtl/rdt_class_queue.sv
// In-order queue of outstanding requests for one priority class.
// Each entry holds a tag and a length (beats minus one). Beats count down
// the head entry, which retires on its final beat.
// Assumes: the caller never pushes while count == DEPTH, and applies
// beat only while the queue is not empty.
module rdt_class_queue #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 3,
    parameter int LEN_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [TAG_W-1:0]         push_tag,
    input  logic [LEN_W-1:0]         push_len,
    input  logic                     beat,
    output logic                     empty,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                     retire,
    output logic [TAG_W-1:0]         retire_tag
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [LEN_W-1:0] seen;

    // Head status and final-beat detection
    always_comb begin
        empty      = (count == '0);
        retire     = beat && !empty && (seen == len_mem[rd_ptr]);
        retire_tag = tag_mem[rd_ptr];
    end

    // Entry storage written on push
    always_ff @(posedge clk) begin
        if (push) begin
            tag_mem[wr_ptr] <= push_tag;
            len_mem[wr_ptr] <= push_len;
        end
    end

    // Pointers, occupancy and head beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            seen   <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (beat && !empty) begin
                if (retire) begin
                    seen   <= '0;
                    rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                end else begin
                    seen <= seen + 1'b1;
                end
            end
            case ({push, retire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CNT_W'(DEPTH)));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/rdt_rx_level.sv
// Occupancy model of the low-priority receive buffer and the buffer-full
// output with hysteresis around BUF_BEATS - MAX_BEATS.
// Assumes: fill and take are single-beat strobes; occupancy saturates.
module rdt_rx_level #(
    parameter int BUF_BEATS = 8,
    parameter int MAX_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fill,
    input  logic take,
    output logic buf_full
);

    localparam int OCC_W = $clog2(BUF_BEATS + 1);
    localparam int THR   = BUF_BEATS - MAX_BEATS;

    logic [OCC_W-1:0] occ, occ_nxt;

    // Next occupancy with saturation at both ends
    always_comb begin
        occ_nxt = occ;
        case ({fill, take})
            2'b10: if (occ != OCC_W'(BUF_BEATS)) occ_nxt = occ + 1'b1;
            2'b01: if (occ != '0)                occ_nxt = occ - 1'b1;
            default: occ_nxt = occ;
        endcase
    end

    // Occupancy register and hysteretic buffer-full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            buf_full <= 1'b0;
        end else begin
            occ <= occ_nxt;
            if (int'(occ_nxt) > THR)
                buf_full <= 1'b1;
            else if (int'(occ_nxt) < THR)
                buf_full <= 1'b0;
        end
    end

    // R7
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> (int'(occ) > THR));

    // R7
    full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full) |-> (int'(occ) < THR));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= BUF_BEATS);

endmodule

// File: rtl/rd_return_tracker.sv
// Tracks pipelined read requests awaiting return data, split by priority.
// Hands out sequential tags, decodes grant-qualified arbiter status,
// counts data beats against the head of each class, reports completions
// one cycle after the final beat, and back-pressures low-priority returns.
// Assumes: at most one status code per cycle, so at most one completion.
module rd_return_tracker #(
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 3,
    parameter int LEN_W     = 2,
    parameter int BUF_BEATS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_hi,
    input  logic [LEN_W-1:0] req_len,
    input  logic             arb_gnt,
    input  logic [2:0]       arb_status,
    input  logic             rd_beat,
    input  logic             rxbuf_take,
    output logic             tracker_full,
    output logic             rd_buf_full,
    output logic             done_valid,
    output logic             done_hi,
    output logic [TAG_W-1:0] done_tag,
    output logic             proto_err
);

    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int MAX_BEATS = 1 << LEN_W;

    logic             lo_ret, hi_ret;
    logic             accept;
    logic [TAG_W-1:0] next_tag;
    logic             q_push  [2];
    logic             q_beat  [2];
    logic             q_empty [2];
    logic [CNT_W-1:0] q_count [2];
    logic             q_ret   [2];
    logic [TAG_W-1:0] q_tag   [2];
    logic [CNT_W:0]   total;

    rdt_status_decode u_dec (
        .gnt    (arb_gnt),
        .status (arb_status),
        .lo_ret (lo_ret),
        .hi_ret (hi_ret)
    );

    // Admission, per-class push and beat steering
    always_comb begin
        total      = {1'b0, q_count[0]} + {1'b0, q_count[1]};
        tracker_full = (total == (CNT_W + 1)'(DEPTH));
        accept     = req_valid && !tracker_full;
        q_push[0]  = accept && !req_hi;
        q_push[1]  = accept &&  req_hi;
        q_beat[0]  = lo_ret && rd_beat && !q_empty[0];
        q_beat[1]  = hi_ret && rd_beat && !q_empty[1];
    end

    // Index 0 holds low priority, index 1 high priority
    for (genvar c = 0; c < 2; c++) begin : g_class
        rdt_class_queue #(
            .DEPTH (DEPTH),
            .TAG_W (TAG_W),
            .LEN_W (LEN_W)
        ) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (q_push[c]),
            .push_tag   (next_tag),
            .push_len   (req_len),
            .beat       (q_beat[c]),
            .empty      (q_empty[c]),
            .count      (q_count[c]),
            .retire     (q_ret[c]),
            .retire_tag (q_tag[c])
        );
    end

    rdt_rx_level #(
        .BUF_BEATS (BUF_BEATS),
        .MAX_BEATS (MAX_BEATS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (q_beat[0]),
        .take     (rxbuf_take),
        .buf_full (rd_buf_full)
    );

    // Tag sequencer, completion register and sticky protocol error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_tag   <= '0;
            done_valid <= 1'b0;
            done_hi    <= 1'b0;
            done_tag   <= '0;
            proto_err  <= 1'b0;
        end else begin
            if (accept)
                next_tag <= next_tag + 1'b1;
            done_valid <= q_ret[0] || q_ret[1];
            done_hi    <= q_ret[1];
            done_tag   <= q_ret[1] ? q_tag[1] : q_tag[0];
            if ((lo_ret && q_empty[0]) || (hi_ret && q_empty[1]))
                proto_err <= 1'b1;
        end
    end

    // R1
    gnt_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_gnt |=> !done_valid);

    // R3
    non_read_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_gnt && (arb_status[2] || arb_status[1])) |=> (!done_valid && $stable(proto_err)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R6
    outstanding_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total <= (CNT_W + 1)'(DEPTH));

endmodule

// File: tb/rd_return_tracker_tb.sv
module rd_return_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_hi;
    logic [1:0] req_len;
    logic       arb_gnt;
    logic [2:0] arb_status;
    logic       rd_beat, rxbuf_take;
    logic       tracker_full, rd_buf_full, done_valid, done_hi, proto_err;
    logic [2:0] done_tag;

    int checks = 0;
    int fails  = 0;
    int next_tag = 0;

    always #10 clk = ~clk;

    rd_return_tracker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_hi       (req_hi),
        .req_len      (req_len),
        .arb_gnt      (arb_gnt),
        .arb_status   (arb_status),
        .rd_beat      (rd_beat),
        .rxbuf_take   (rxbuf_take),
        .tracker_full (tracker_full),
        .rd_buf_full  (rd_buf_full),
        .done_valid   (done_valid),
        .done_hi      (done_hi),
        .done_tag     (done_tag),
        .proto_err    (proto_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        req_valid  = 1'b0;
        req_hi     = 1'b0;
        req_len    = 2'd0;
        arb_gnt    = 1'b0;
        arb_status = 3'b111;
        rd_beat    = 1'b0;
        rxbuf_take = 1'b0;
    endtask

    task automatic enq(input bit hi, input int len);
        req_valid = 1'b1;
        req_hi    = hi;
        req_len   = 2'(len);
        tick;
        idle;
    endtask

    task automatic ret(input logic [2:0] st, input bit g, input bit tk);
        arb_gnt    = g;
        arb_status = st;
        rd_beat    = 1'b1;
        rxbuf_take = tk;
        tick;
        idle;
    endtask

    task automatic take1;
        rxbuf_take = 1'b1;
        tick;
        idle;
    endtask

    task automatic chk_done(input string req, input int tag, input bit hi);
        chk(done_valid && done_tag == 3'(tag) && done_hi == hi, req,
            done_valid ? int'(done_tag) : -1, tag);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3;
        idle;
        rst_n = 1'b0;
        repeat (3) tick;
        // R10 reset state
        chk(!tracker_full && !rd_buf_full && !done_valid && !proto_err, "R10",
            {tracker_full, rd_buf_full, done_valid, proto_err}, 0);
        rst_n = 1'b1;
        tick;

        // R2 R5 R4: sweep both classes over all lengths
        for (int hi = 0; hi < 2; hi++) begin
            for (int len = 0; len < 4; len++) begin
                t0 = next_tag % 8;
                enq(hi[0], len);
                next_tag++;
                for (int b = 0; b <= len; b++) begin
                    ret(hi ? 3'b001 : 3'b000, 1'b1, !hi[0]);
                    if (b < len)
                        chk(!done_valid, "R5 early", int'(done_valid), 0);
                    else
                        chk_done("R2 R5", t0, hi[0]);
                end
                tick;
                chk(!done_valid, "R5 pulse", int'(done_valid), 0);
            end
        end

        // R6 R4: fill to four, blocked enqueue, out-of-class ordering
        t0 = next_tag % 8; enq(1'b0, 1); next_tag++;
        t1 = next_tag % 8; enq(1'b1, 0); next_tag++;
        t2 = next_tag % 8; enq(1'b0, 0); next_tag++;
        t3 = next_tag % 8; enq(1'b1, 0); next_tag++;
        chk(tracker_full, "R6 full", int'(tracker_full), 1);
        enq(1'b0, 0);
        chk(tracker_full, "R6 blocked", int'(tracker_full), 1);
        ret(3'b001, 1'b1, 1'b0);
        chk_done("R4 hi first", t1, 1'b1);
        chk(!tracker_full, "R6 release", int'(tracker_full), 0);
        ret(3'b000, 1'b1, 1'b1);
        chk(!done_valid, "R5 len1", int'(done_valid), 0);
        ret(3'b000, 1'b1, 1'b1);
        chk_done("R4 lo order", t0, 1'b0);
        ret(3'b001, 1'b1, 1'b0);
        chk_done("R4 hi order", t3, 1'b1);
        ret(3'b000, 1'b1, 1'b1);
        chk_done("R4 lo order2", t2, 1'b0);
        t0 = next_tag % 8; enq(1'b0, 0); next_tag++;
        ret(3'b000, 1'b1, 1'b1);
        chk_done("R6 no tag consumed", t0, 1'b0);

        // R1: grant low, status ignored
        t0 = next_tag % 8; enq(1'b0, 0); next_tag++;
        ret(3'b000, 1'b0, 1'b0);
        chk(!done_valid && !proto_err, "R1", int'(done_valid) + int'(proto_err), 0);
        ret(3'b001, 1'b0, 1'b0);
        chk(!done_valid && !proto_err, "R1 hi", int'(done_valid) + int'(proto_err), 0);
        // R3: every non-read code under grant
        for (int s = 2; s < 8; s++) begin
            ret(3'(s), 1'b1, 1'b0);
            chk(!done_valid && !proto_err, "R3", s, 0);
        end
        ret(3'b000, 1'b1, 1'b1);
        chk_done("R1 R3 queue intact", t0, 1'b0);

        // R7 R8: buffer-full hysteresis, high returns unaffected
        t0 = next_tag % 8; enq(1'b0, 3); next_tag++;
        t1 = next_tag % 8; enq(1'b0, 3); next_tag++;
        t2 = next_tag % 8; enq(1'b1, 0); next_tag++;
        for (int b = 0; b < 4; b++) ret(3'b000, 1'b1, 1'b0);
        chk_done("R7 first lo", t0, 1'b0);
        chk(!rd_buf_full, "R7 occ4 hold low", int'(rd_buf_full), 0);
        ret(3'b000, 1'b1, 1'b0);
        chk(rd_buf_full, "R7 occ5 set", int'(rd_buf_full), 1);
        ret(3'b001, 1'b1, 1'b0);
        chk_done("R8 hi not blocked", t2, 1'b1);
        chk(rd_buf_full, "R8 occ unchanged", int'(rd_buf_full), 1);
        take1;
        chk(rd_buf_full, "R7 occ4 hold high", int'(rd_buf_full), 1);
        take1;
        chk(!rd_buf_full, "R7 occ3 clear", int'(rd_buf_full), 0);
        for (int b = 0; b < 3; b++) ret(3'b000, 1'b1, 1'b1);
        chk_done("R7 second lo", t1, 1'b0);
        repeat (3) take1;
        chk(!proto_err, "R9 clean", int'(proto_err), 0);

        // R9: sticky error on return with empty class
        arb_gnt = 1'b1; arb_status = 3'b001;
        tick;
        idle;
        chk(proto_err, "R9 set", int'(proto_err), 1);
        repeat (3) tick;
        chk(proto_err, "R9 sticky", int'(proto_err), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule